// File: doc/BRIEF.md
# Mixed-Criticality Dual-Lane Issue Selector

This block picks the instructions for a two-lane issue stage in a multithreaded core with sixteen hardware thread contexts. The contexts form two groups of eight. The first group is hard real-time (HRT) and the second is best-effort (NHRT). Each group has its own round-robin pointer, and both pointers step forward on every clock. In any cycle the fetch logic shows the block up to two candidate instructions from the current HRT thread and up to two from the current NHRT thread. For each pair it also gives a flag that says the second instruction of the pair depends on the first.

The selector always grants the HRT thread's instructions first. A lane the HRT thread leaves empty goes to the NHRT thread in the same cycle. A lane is left empty when the HRT pair is dependent, when a slot is empty, or when the HRT thread is not active. Each lane grant carries a thread ID and the slot index of the chosen instruction. The pointer outputs tell fetch which two threads to present. The grant logic is combinational on the current pointers and inputs; the pointers are the only registers.

Top module: `smt_issue_sched`

## Requirements
- R1: While rst_n is low, both hrtPtr and nhrtPtr read 0.
- R2: After reset, on every rising clock edge each pointer goes up by one and wraps from 7 to 0. This happens whatever was issued and whatever the active flags are.
- R3: A candidate is live when its thread's active bit is 1 and its slot valid bit is 1. Live HRT candidates are granted before any NHRT candidate. Lane 0 is filled before lane 1, and slot 0 goes before slot 1.
- R4: When hrtPairDep is 1 and both HRT slots are live, only HRT slot 0 is granted.
- R5: Lanes the HRT thread leaves empty are filled from the live NHRT candidates in the same cycle, slot 0 before slot 1.
- R6: When nhrtPairDep is 1 and both NHRT slots are live, at most NHRT slot 0 is granted.
- R7: A thread whose active bit (hrtActive[hrtPtr] or nhrtActive[nhrtPtr]) is 0 gets no grant, even if its slot valid bits are 1.
- R8: Thread ID encoding: an HRT grant reports tid = hrtPtr (0 to 7). An NHRT grant reports tid = 8 + nhrtPtr (8 to 15). The slot field is 0 for slot 0 and 1 for slot 1.
- R9: An unfilled lane drives valid = 0, tid = 0 and slot = 0.
- R10: lane1Valid is 1 only when lane0Valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hrtActive | input | 8 | Active flag per HRT thread |
| nhrtActive | input | 8 | Active flag per NHRT thread |
| hrtSlotValid | input | 2 | Candidate valid bits of the current HRT thread |
| hrtPairDep | input | 1 | HRT slot 1 depends on HRT slot 0 |
| nhrtSlotValid | input | 2 | Candidate valid bits of the current NHRT thread |
| nhrtPairDep | input | 1 | NHRT slot 1 depends on NHRT slot 0 |
| hrtPtr | output | 3 | Current HRT thread index |
| nhrtPtr | output | 3 | Current NHRT thread index |
| lane0Valid | output | 1 | Lane 0 carries an instruction |
| lane0Tid | output | 4 | Lane 0 thread ID |
| lane0Slot | output | 1 | Lane 0 slot index |
| lane1Valid | output | 1 | Lane 1 carries an instruction |
| lane1Tid | output | 4 | Lane 1 thread ID |
| lane1Slot | output | 1 | Lane 1 slot index |

## Verification
The bench targets a dependent HRT pair next to an NHRT pair that is free to fill the spare lane. A design that ignores the dependency would put both HRT instructions into the lanes, and one that refills badly would leave lane 1 empty. It drives valid slots on inactive threads, where a selector that ignores the active flag would grant work from a dormant context. It also drives a lone slot-1 candidate, where a wrong packer would put it in lane 1 and leave a hole in lane 0. Pointer wrap is checked against a model that keeps counting while issue stops entirely, which catches a pointer that stalls on idle cycles or skips a thread.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;
  parameter int unsigned GROUP_SIZE = 8;        // threads per criticality group, power of two
  localparam int unsigned PTR_W = $clog2(GROUP_SIZE);
  localparam int unsigned TID_W = PTR_W + 1;    // top bit marks the best-effort group
  localparam int unsigned SLOTS = 2;

  typedef struct packed {
    logic             valid;
    logic [TID_W-1:0] tid;
    logic             slot;
  } laneGrant_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             hrtLive;
    logic             nhrtLive;
    logic [PTR_W-1:0] hrtPtr;
    logic [PTR_W-1:0] nhrtPtr;
  } schedStrobe_t;
endpackage

// File: rtl/smt_rr_pointer.sv
module smt_rr_pointer
  import smt_issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(GROUP_SIZE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)           ptr <= '0;
    else if (ptr == LAST) ptr <= '0;
    else                  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/smt_issue_ctrl.sv
module smt_issue_ctrl
  import smt_issue_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_SIZE-1:0] hrtActive,
  input  logic [GROUP_SIZE-1:0] nhrtActive,
  output schedStrobe_t          strobe
);
  localparam int unsigned GROUPS = 2;

  logic [GROUP_SIZE-1:0] activeVec [GROUPS];
  logic [PTR_W-1:0]      grpPtr    [GROUPS];
  logic                  grpLive   [GROUPS];

  assign activeVec[0] = hrtActive;
  assign activeVec[1] = nhrtActive;

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    smt_rr_pointer u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .ptr  (grpPtr[g])
    );
    assign grpLive[g] = activeVec[g][grpPtr[g]];
  end

  always_comb begin
    strobe.hrtPtr   = grpPtr[0];
    strobe.nhrtPtr  = grpPtr[1];
    strobe.hrtLive  = grpLive[0];
    strobe.nhrtLive = grpLive[1];
  end
endmodule

// File: rtl/smt_issue_dpath.sv
module smt_issue_dpath
  import smt_issue_pkg::*;
(
  input  schedStrobe_t     strobe,
  input  logic [SLOTS-1:0] hrtSlotValid,
  input  logic             hrtPairDep,
  input  logic [SLOTS-1:0] nhrtSlotValid,
  input  logic             nhrtPairDep,
  output laneGrant_t       lane0,
  output laneGrant_t       lane1
);
  localparam int unsigned CANDS = 2 * SLOTS;

  laneGrant_t cand [CANDS];

  // candidate order: HRT slot0, HRT slot1, NHRT slot0, NHRT slot1
  always_comb begin
    cand[0].valid = strobe.hrtLive & hrtSlotValid[0];
    cand[0].tid   = {1'b0, strobe.hrtPtr};
    cand[0].slot  = 1'b0;
    cand[1].valid = strobe.hrtLive & hrtSlotValid[1] & ~(hrtPairDep & hrtSlotValid[0]);
    cand[1].tid   = {1'b0, strobe.hrtPtr};
    cand[1].slot  = 1'b1;
    cand[2].valid = strobe.nhrtLive & nhrtSlotValid[0];
    cand[2].tid   = {1'b1, strobe.nhrtPtr};
    cand[2].slot  = 1'b0;
    cand[3].valid = strobe.nhrtLive & nhrtSlotValid[1] & ~(nhrtPairDep & nhrtSlotValid[0]);
    cand[3].tid   = {1'b1, strobe.nhrtPtr};
    cand[3].slot  = 1'b1;
  end

  // priority packing into the two lanes
  always_comb begin
    lane0 = '0;
    lane1 = '0;
    for (int k = 0; k < CANDS; k++) begin
      if (cand[k].valid) begin
        if (!lane0.valid)      lane0 = cand[k];
        else if (!lane1.valid) lane1 = cand[k];
      end
    end
  end
endmodule

// File: rtl/smt_issue_sched.sv
module smt_issue_sched
  import smt_issue_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_SIZE-1:0] hrtActive,
  input  logic [GROUP_SIZE-1:0] nhrtActive,
  input  logic [SLOTS-1:0]      hrtSlotValid,
  input  logic                  hrtPairDep,
  input  logic [SLOTS-1:0]      nhrtSlotValid,
  input  logic                  nhrtPairDep,
  output logic [PTR_W-1:0]      hrtPtr,
  output logic [PTR_W-1:0]      nhrtPtr,
  output logic                  lane0Valid,
  output logic [TID_W-1:0]      lane0Tid,
  output logic                  lane0Slot,
  output logic                  lane1Valid,
  output logic [TID_W-1:0]      lane1Tid,
  output logic                  lane1Slot
);
  schedStrobe_t strobe;
  laneGrant_t   lane0, lane1;

  smt_issue_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hrtActive (hrtActive),
    .nhrtActive(nhrtActive),
    .strobe    (strobe)
  );

  smt_issue_dpath u_dpath (
    .strobe       (strobe),
    .hrtSlotValid (hrtSlotValid),
    .hrtPairDep   (hrtPairDep),
    .nhrtSlotValid(nhrtSlotValid),
    .nhrtPairDep  (nhrtPairDep),
    .lane0        (lane0),
    .lane1        (lane1)
  );

  assign hrtPtr     = strobe.hrtPtr;
  assign nhrtPtr    = strobe.nhrtPtr;
  assign lane0Valid = lane0.valid;
  assign lane0Tid   = lane0.tid;
  assign lane0Slot  = lane0.slot;
  assign lane1Valid = lane1.valid;
  assign lane1Tid   = lane1.tid;
  assign lane1Slot  = lane1.slot;
endmodule

// File: rtl/smt_issue_sched_chk.sv
module smt_issue_sched_chk
  import smt_issue_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [GROUP_SIZE-1:0] hrtActive,
  input logic [GROUP_SIZE-1:0] nhrtActive,
  input logic [SLOTS-1:0]      hrtSlotValid,
  input logic                  hrtPairDep,
  input logic [PTR_W-1:0]      hrtPtr,
  input logic [PTR_W-1:0]      nhrtPtr,
  input logic                  lane0Valid,
  input logic [TID_W-1:0]      lane0Tid,
  input logic                  lane0Slot,
  input logic                  lane1Valid,
  input logic [TID_W-1:0]      lane1Tid
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(GROUP_SIZE - 1);

  a_r2_hrt_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hrtPtr == (($past(hrtPtr) == LAST) ? '0 : $past(hrtPtr) + 1'b1));

  a_r2_nhrt_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> nhrtPtr == (($past(nhrtPtr) == LAST) ? '0 : $past(nhrtPtr) + 1'b1));

  a_r3_hrt_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hrtActive[hrtPtr] && hrtSlotValid[0]) |->
      (lane0Valid && lane0Tid == {1'b0, hrtPtr} && !lane0Slot));

  a_r4_dep_single: assert property (@(posedge clk) disable iff (!rst_n)
    (hrtActive[hrtPtr] && hrtSlotValid == 2'b11 && hrtPairDep) |->
      !(lane1Valid && !lane1Tid[TID_W-1]));

  a_r7_nhrt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !nhrtActive[nhrtPtr] |->
      !(lane0Valid && lane0Tid[TID_W-1]) && !(lane1Valid && lane1Tid[TID_W-1]));

  a_r9_nop_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    !lane0Valid |-> (lane0Tid == '0 && !lane0Slot));

  a_r10_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    lane1Valid |-> lane0Valid);
endmodule

bind smt_issue_sched smt_issue_sched_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hrtActive   (hrtActive),
  .nhrtActive  (nhrtActive),
  .hrtSlotValid(hrtSlotValid),
  .hrtPairDep  (hrtPairDep),
  .hrtPtr      (hrtPtr),
  .nhrtPtr     (nhrtPtr),
  .lane0Valid  (lane0Valid),
  .lane0Tid    (lane0Tid),
  .lane0Slot   (lane0Slot),
  .lane1Valid  (lane1Valid),
  .lane1Tid    (lane1Tid)
);

// File: tb/smt_issue_sched_tb.sv
module smt_issue_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hrtActive = '0, nhrtActive = '0;
  logic [1:0] hrtSlotValid = '0, nhrtSlotValid = '0;
  logic       hrtPairDep = 1'b0, nhrtPairDep = 1'b0;
  logic [2:0] hrtPtr, nhrtPtr;
  logic       lane0Valid, lane0Slot, lane1Valid, lane1Slot;
  logic [3:0] lane0Tid, lane1Tid;

  int errors = 0;
  int checks = 0;
  int expH = 0;
  int expN = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smt_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .hrtActive(hrtActive), .nhrtActive(nhrtActive),
    .hrtSlotValid(hrtSlotValid), .hrtPairDep(hrtPairDep),
    .nhrtSlotValid(nhrtSlotValid), .nhrtPairDep(nhrtPairDep),
    .hrtPtr(hrtPtr), .nhrtPtr(nhrtPtr),
    .lane0Valid(lane0Valid), .lane0Tid(lane0Tid), .lane0Slot(lane0Slot),
    .lane1Valid(lane1Valid), .lane1Tid(lane1Tid), .lane1Slot(lane1Slot)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: list of granted {tid,slot} codes in order
  task automatic compare(string req);
    int q[$];
    logic [15:0] exp, act;
    if (hrtActive[expH]) begin
      if (hrtSlotValid[0]) q.push_back(expH * 2);
      if (hrtSlotValid[1] && !(hrtPairDep && hrtSlotValid[0])) q.push_back(expH * 2 + 1);
    end
    if (nhrtActive[expN]) begin
      if (nhrtSlotValid[0]) q.push_back((8 + expN) * 2);
      if (nhrtSlotValid[1] && !(nhrtPairDep && nhrtSlotValid[0])) q.push_back((8 + expN) * 2 + 1);
    end
    exp = '0;
    exp[15:13] = 3'(expH);
    exp[12:10] = 3'(expN);
    if (q.size() > 0) begin exp[9] = 1'b1; exp[8:4] = 5'(q[0]); end
    if (q.size() > 1) begin exp[3] = 1'b1; exp[2:0] = 3'(0); exp[7:0] = exp[7:0]; end
    act = {hrtPtr, nhrtPtr, lane0Valid, lane0Tid, lane0Slot, lane1Valid, 3'b000};
    // lane1 content compared separately to keep the packing simple
    check(req, act, exp);
    checks++;
    if (q.size() > 1) begin
      if ({lane1Tid, lane1Slot} !== 5'(q[1])) begin
        errors++;
        $display("FAIL %s lane1: actual=%h expected=%h at %0t", req, {lane1Tid, lane1Slot}, 5'(q[1]), $time);
      end
    end else if ({lane1Tid, lane1Slot} !== 5'd0) begin
      errors++;
      $display("FAIL R9 lane1 idle: actual=%h expected=0 at %0t", {lane1Tid, lane1Slot}, $time);
    end
  endtask

  // sample at negedge, then step a clock and advance the model
  task automatic step(string req);
    @(negedge clk);
    compare(req);
    @(posedge clk);
    expH = (expH + 1) % 8;
    expN = (expN + 1) % 8;
    #2;
  endtask

  task automatic drive(logic [7:0] ha, logic [7:0] na, logic [1:0] hs, logic hd,
                       logic [1:0] ns, logic nd);
    hrtActive = ha; nhrtActive = na;
    hrtSlotValid = hs; hrtPairDep = hd;
    nhrtSlotValid = ns; nhrtPairDep = nd;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    drive(8'hFF, 8'hFF, 2'b11, 1'b0, 2'b11, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pointers", {10'd0, hrtPtr, nhrtPtr}, 16'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    // R3: both HRT instructions take both lanes
    step("R3 hrt pair fills lanes");
    // R4 and R5: dependent HRT pair, NHRT slot 0 fills lane 1
    drive(8'hFF, 8'hFF, 2'b11, 1'b1, 2'b11, 1'b0);
    step("R4 R5 hrt dep fill");
    // R6: both pairs dependent
    drive(8'hFF, 8'hFF, 2'b11, 1'b1, 2'b11, 1'b1);
    step("R6 nhrt dep");
    // R7: HRT inactive, NHRT takes both lanes
    drive(8'h00, 8'hFF, 2'b11, 1'b0, 2'b11, 1'b0);
    step("R7 R5 hrt inactive");
    // R7 R9: both inactive, no grants
    drive(8'h00, 8'h00, 2'b11, 1'b0, 2'b11, 1'b0);
    step("R7 R9 all inactive");
    // R3 R10: lone HRT slot 1 goes to lane 0
    drive(8'hFF, 8'h00, 2'b10, 1'b1, 2'b11, 1'b0);
    step("R3 R10 lone slot1");
    // R8: NHRT thread ids, HRT empty slots
    drive(8'hFF, 8'hFF, 2'b00, 1'b0, 2'b10, 1'b0);
    step("R8 nhrt tid");
    // R2: pointers keep stepping with nothing issued, across wrap
    drive(8'h00, 8'h00, 2'b00, 1'b0, 2'b00, 1'b0);
    for (int i = 0; i < 10; i++) step("R2 idle stepping");
    // R7: only some threads active, checked per pointer position
    drive(8'b0101_0101, 8'b1010_1010, 2'b11, 1'b0, 2'b01, 1'b0);
    for (int i = 0; i < 16; i++) step("R7 R8 partial activity");
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      drive(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom));
      step("R3 R4 R5 R6 mixed");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule